// File: doc/BRIEF.md
# Two-Step Fork-Join Process Sequencer

This controller coordinates a group of operation controllers that a schedule has placed into two control steps. Within a step the processes run in parallel. The steps run strictly one after another. The block talks to its parent over one four-phase request/acknowledge pair and to each child process over its own pair. A parent request forks out to every process of the first step. Their acknowledges are joined, which starts the second step. The joined acknowledges of the second step complete the parent handshake.

The return-to-zero half is ordered as well. Process requests are held until the parent request drops, and then all of them drop together. The parent acknowledge is withdrawn only after every child acknowledge has returned low. A new round therefore cannot start any process while any process of the previous round is still in its idling phase. This keeps two processes that share a functional unit or a register from overlapping.

The block is synchronous: every handshake input is sampled on the rising clock edge, and every output comes straight from a register. The number of processes per step is a parameter. Process `p` of step `s` uses bit `s*PROCS+p` of the process buses.

Top module: `fj_seq_ctrl`

## Requirements
- R1: After reset, every process request and the upstream acknowledge are low.
- R2: An upstream request sampled high while the block is idle, with every process acknowledge low, raises all step-0 requests (bits 0 to PROCS-1) together on that same edge.
- R3: All step-1 requests (bits PROCS to 2*PROCS-1) rise together, and only on an edge where every step-0 acknowledge is sampled high. When the children answer after D cycles each, step 1 starts exactly max(step-0 D) edges after step 0 starts.
- R4: The upstream acknowledge rises only on an edge where every process acknowledge is high. It rises max(step-0 D) + max(step-1 D) edges after the edge that sampled the upstream request.
- R5: Process requests stay high until the upstream request is sampled low. All of them fall together on the first edge that samples the upstream request low, and never while it is high.
- R6: The upstream acknowledge falls only on an edge where every process acknowledge is low and every process request is low. It falls max(all D) edges after the edge where the requests fell.
- R7: A process request never rises on an edge where that process's own acknowledge is sampled high.
- R8: Step-0 requests of a new round never rise while the upstream acknowledge or any process acknowledge is still high, including when the parent re-requests in the very cycle its acknowledge falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req_i | input | 1 | Upstream four-phase request |
| up_ack_o | output | 1 | Upstream four-phase acknowledge |
| proc_req_o | output | 2*PROCS | Per-process requests, bit s*PROCS+p for process p of step s |
| proc_ack_i | input | 2*PROCS | Per-process acknowledges, same bit order |

## Verification
Two events can fall on one edge. The first is the completion of the return phase, where the upstream acknowledge falls. The second is a new upstream request arriving at the same moment. The bench provokes this by raising the parent request in the same half-cycle that it observes the acknowledge low, and it sweeps every child delay combination from one to four cycles. It judges the overlap by checking that step-0 requests rise only on a later edge, once every acknowledge is low. It also checks that the latency of the new round matches the arithmetic delay sum. The gap between rounds is varied over zero, one and two cycles.

// File: rtl/fj_pkg.sv
package fj_pkg;
  localparam int unsigned STEPS = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STEP0  = 3'd1,
    ST_STEP1  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RETURN = 3'd4
  } seq_state_t;
endpackage

// File: rtl/fj_ack_join.sv
module fj_ack_join #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] ack_i,
  output logic         all_hi_o,
  output logic         all_lo_o
);
  always_comb begin
    all_hi_o = &ack_i;
    all_lo_o = ~|ack_i;
  end
endmodule

// File: rtl/fj_proc_slot.sv
module fj_proc_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;
  logic req_d;
  logic req_en;

  always_comb begin
    req_en = clr_i | (set_i & ~ack_i);
    req_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // R7: a request never rises against its own high acknowledge
  assert_no_rise_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_i));
endmodule

// File: rtl/fj_seq_fsm.sv
module fj_seq_fsm
  import fj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req_i,
  input  logic [STEPS-1:0] step_hi_i,
  input  logic             all_lo_i,
  output logic [STEPS-1:0] step_set_o,
  output logic             clr_o,
  output logic             up_ack_o
);
  seq_state_t st_q, st_d;
  logic       ack_q, ack_d, ack_en;

  always_comb begin
    st_d       = st_q;
    step_set_o = '0;
    clr_o      = 1'b0;
    ack_en     = 1'b0;
    ack_d      = ack_q;
    unique case (st_q)
      ST_IDLE: begin
        if (up_req_i && all_lo_i) begin
          step_set_o[0] = 1'b1;
          st_d          = ST_STEP0;
        end
      end
      ST_STEP0: begin
        if (step_hi_i[0]) begin
          step_set_o[1] = 1'b1;
          st_d          = ST_STEP1;
        end
      end
      ST_STEP1: begin
        if (step_hi_i[1]) begin
          ack_en = 1'b1;
          ack_d  = 1'b1;
          st_d   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!up_req_i) begin
          clr_o = 1'b1;
          st_d  = ST_RETURN;
        end
      end
      ST_RETURN: begin
        if (all_lo_i) begin
          ack_en = 1'b1;
          ack_d  = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (ack_en) begin
      ack_q <= ack_d;
    end
  end

  assign up_ack_o = ack_q;

  // R2: step 0 is only launched from idle by a live parent request
  assert_fork_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STEP0 && $past(st_q) != ST_STEP0) |-> $past(up_req_i));
endmodule

// File: rtl/fj_seq_ctrl.sv
module fj_seq_ctrl
  import fj_pkg::*;
#(
  parameter int unsigned PROCS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     up_req_i,
  output logic                     up_ack_o,
  output logic [STEPS*PROCS-1:0]   proc_req_o,
  input  logic [STEPS*PROCS-1:0]   proc_ack_i
);
  localparam int unsigned TOTAL = STEPS * PROCS;

  logic [1:0]       rst_sync_q;
  logic             rst_q;
  logic [STEPS-1:0] step_hi;
  logic [STEPS-1:0] step_lo;
  logic [STEPS-1:0] step_set;
  logic             clr;
  logic             all_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  for (genvar s = 0; s < STEPS; s++) begin : g_join
    fj_ack_join #(.W(PROCS)) u_join (
      .ack_i    (proc_ack_i[s*PROCS +: PROCS]),
      .all_hi_o (step_hi[s]),
      .all_lo_o (step_lo[s])
    );
  end

  assign all_lo = &step_lo;

  fj_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q),
    .up_req_i   (up_req_i),
    .step_hi_i  (step_hi),
    .all_lo_i   (all_lo),
    .step_set_o (step_set),
    .clr_o      (clr),
    .up_ack_o   (up_ack_o)
  );

  for (genvar k = 0; k < TOTAL; k++) begin : g_slot
    fj_proc_slot u_slot (
      .clk   (clk),
      .rst_n (rst_q),
      .set_i (step_set[k / PROCS]),
      .clr_i (clr),
      .ack_i (proc_ack_i[k]),
      .req_o (proc_req_o[k])
    );
  end

  // R3: step 1 starts only after every step-0 acknowledge was high
  assert_join_step0_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(|proc_req_o[TOTAL-1:PROCS]) |-> &$past(proc_ack_i[PROCS-1:0]));

  // R4: parent acknowledge rises only with every child acknowledge high
  assert_join_all_R4: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(up_ack_o) |-> &$past(proc_ack_i));

  // R5: requests drop only once the parent request has been sampled low
  assert_drop_after_parent_R5: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(|proc_req_o) |-> !$past(up_req_i));

  // R6: parent acknowledge withdrawn only after every child returned to zero
  assert_return_complete_R6: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(up_ack_o) |-> (!$past(|proc_ack_i) && !$past(|proc_req_o)));

  // R8: a new round never overlaps the idling phase of the previous one
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(|proc_req_o[PROCS-1:0]) |-> (!$past(up_ack_o) && !$past(|proc_ack_i)));
endmodule

// File: tb/fj_seq_ctrl_tb.sv
`timescale 1ns/1ps
module fj_seq_ctrl_tb;
  localparam int P = 2;
  localparam int N = 2 * P;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_req = 1'b0;
  logic         up_ack;
  logic [N-1:0] preq;
  logic [N-1:0] pack = '0;

  int vectors = 0;
  int miscompares = 0;
  int dly [N];
  int cnt [N];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fj_seq_ctrl #(.PROCS(P)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_req_i   (up_req),
    .up_ack_o   (up_ack),
    .proc_req_o (preq),
    .proc_ack_i (pack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // child controller model: acknowledge follows request after dly[k] cycles
  always @(negedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!rst_n) begin
        pack[k] <= 1'b0;
        cnt[k] = 0;
      end else if (pack[k] != preq[k]) begin
        cnt[k] = cnt[k] + 1;
        if (cnt[k] >= dly[k]) begin
          pack[k] <= preq[k];
          cnt[k] = 0;
        end
      end else begin
        cnt[k] = 0;
      end
    end
  end

  // ordering monitor, sampled just after each rising edge
  logic [N-1:0] prev_req;
  logic         prev_ack;
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      logic [P-1:0] s0, s1, ps0, ps1;
      s0 = preq[P-1:0];  s1 = preq[N-1:P];
      ps0 = prev_req[P-1:0]; ps1 = prev_req[N-1:P];
      if (s0 != '0 && s0 != '1) check(0, "R2 step0 split", int'(s0), 0);
      if (s1 != '0 && s1 != '1) check(0, "R3 step1 split", int'(s1), 0);
      if (ps1 == '0 && s1 != '0)
        check(&pack[P-1:0], "R3 step1 before step0 join", int'(pack[P-1:0]), (1 << P) - 1);
      if (!prev_ack && up_ack)
        check(&pack, "R4 ack before join", int'(pack), (1 << N) - 1);
      if ((prev_req & ~preq) != '0)
        check(!up_req, "R5 drop while parent high", int'(up_req), 0);
      if (prev_ack && !up_ack)
        check(pack == '0 && preq == '0, "R6 early ack fall", int'({preq, pack}), 0);
      for (int k = 0; k < N; k++)
        if (!prev_req[k] && preq[k]) check(!pack[k], "R7 rise on high ack", int'(pack[k]), 0);
      if (ps0 == '0 && s0 != '0)
        check(!prev_ack && pack == '0, "R8 overlap", int'({prev_ack, pack}), 0);
    end
    prev_req = preq;
    prev_ack = up_ack;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int m0, m1, mall, k, gap;
    for (int i = 0; i < N; i++) dly[i] = 1;
    repeat (3) @(negedge clk);
    check(preq == '0, "R1 reset reqs", int'(preq), 0);
    check(up_ack == 1'b0, "R1 reset ack", int'(up_ack), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(preq == '0 && up_ack == 1'b0, "R1 after release", int'({up_ack, preq}), 0);
    prev_req = preq;
    prev_ack = up_ack;
    mon_en = 1'b1;
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < N; i++) dly[i] = ((c >> (2 * i)) & 3) + 1;
      m0 = 0; m1 = 0;
      for (int i = 0; i < P; i++) begin
        if (dly[i] > m0) m0 = dly[i];
        if (dly[P + i] > m1) m1 = dly[P + i];
      end
      mall = (m0 > m1) ? m0 : m1;
      up_req = 1'b1;
      k = 0;
      while (!up_ack && k < 40) begin
        @(negedge clk);
        k++;
        if (k == 1) check(preq == {{P{1'b0}}, {P{1'b1}}}, "R2 fork", int'(preq), (1 << P) - 1);
        if (k == m0 + 1) check(preq == '1, "R3 step1 timing", int'(preq), (1 << N) - 1);
      end
      check(k == m0 + m1 + 1, "R4 latency", k, m0 + m1 + 1);
      repeat (c % 2) @(negedge clk);
      check(preq == '1 && up_ack, "R5 hold", int'({up_ack, preq}), (1 << (N + 1)) - 1);
      up_req = 1'b0;
      k = 0;
      while (up_ack && k < 40) begin
        @(negedge clk);
        k++;
        if (k == 1) check(preq == '0, "R5 drop together", int'(preq), 0);
      end
      check(k == mall + 1, "R6 latency", k, mall + 1);
      gap = c % 3;
      repeat (gap) @(negedge clk);
      if (gap == 0) check(preq == '0, "R8 back-to-back idle", int'(preq), 0);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule